// File: doc/BRIEF.md
# Coalescing Store Write Buffer

This block sits between a processor's store port and a slower memory bus. Stores flagged as bufferable are taken in the same cycle they are presented. They are parked in a small set of entries, each holding a word address, a data word and a byte-lane mask. A later bufferable store to an address that already has a pending entry is folded into that entry: its enabled bytes replace the old ones and the masks are combined. As a result, only the final value of each word is written out. Parked entries are written out only when something asks for it. That can be a drain request, a full buffer blocking a new store, or an access that must go straight to memory. Entries leave in ascending address order, not in arrival order.

Accesses that are not safe to merge or reorder take a separate path. These are stores flagged as nonbufferable, and every read. Such an access waits until every parked entry has reached memory. It is then issued on its own, and it is acknowledged in the cycle the memory completes it. Repeated writes to one device register therefore each appear on the bus, in program order. The buffer reports when it holds nothing and the bus is idle.

Top module: `coalesce_wbuf`

## Requirements
- R1: While reset is held, and right after it, buf_empty is 1 and both mem_req and cpu_ack are 0.
- R2: A bufferable store (cpu_we=1, cpu_buf=1) is acknowledged in the cycle it is presented when a free entry or a matching pending entry exists. Parked entries cause no bus write until a drain is triggered.
- R3: A bufferable store to the address of a pending entry that is not on the bus merges into it. Bytes whose cpu_be bit (bit n covers data bits 8n+7:8n) is set replace the old bytes, the masks are ORed, and one bus write results. A freshly allocated entry holds zero in its unselected bytes.
- R4: Parked entries are written to memory lowest address first.
- R5: When all entries are pending and a bufferable store matches none of the entries that are off the bus, cpu_ack stays 0 until an entry's bus write completes. A store that matches a pending entry is still taken at once.
- R6: A nonbufferable store waits until all earlier entries are written. It is never merged, goes to the bus on its own with its own mask, and is acknowledged in the cycle of its mem_ack.
- R7: A read (cpu_we=0) starts on the bus only after all parked entries are written. It returns mem_rdata on cpu_rdata in the cycle cpu_ack is 1.
- R8: A one-cycle drain_req pulse writes out every parked entry. buf_empty is 1 only when no entry is pending and no bus transfer is open.
- R9: Once mem_req is 1, it and mem_addr, mem_wdata, mem_be and mem_we hold until mem_ack. An entry leaves the buffer only with a completed transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until cpu_ack |
| cpu_we | input | 1 | 1 store, 0 read |
| cpu_buf | input | 1 | Store may be buffered and merged |
| cpu_addr | input | 32 | Word address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Byte-lane enables |
| cpu_ack | output | 1 | Access accepted or completed this cycle |
| cpu_rdata | output | 32 | Read data, valid with cpu_ack |
| drain_req | input | 1 | Write out all parked entries |
| buf_empty | output | 1 | No pending entry and bus idle |
| mem_req | output | 1 | Bus transfer open |
| mem_we | output | 1 | Bus transfer direction |
| mem_addr | output | 32 | Bus word address |
| mem_wdata | output | 32 | Bus write data |
| mem_be | output | 4 | Bus byte-lane enables |
| mem_ack | input | 1 | Transfer completes this cycle |
| mem_rdata | input | 32 | Bus read data |

## Verification
The assertions assume that the processor holds cpu_req and every access field steady until cpu_ack. They also assume that the memory raises mem_ack only while mem_req is 1, for one cycle per transfer. The bench keeps to this in two ways. Every access goes through a task that drops the request just after the acknowledging edge. The memory model answers only an open request, with a single-cycle acknowledge after a settable delay or hold. The one deliberate change of an unacknowledged request comes in the full-buffer scenario. That change redirects a stalled store to a mergeable address, which the design allows while nothing is committed.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE   = 2'd0,
    BUS_FLUSH  = 2'd1,
    BUS_DIRECT = 2'd2
  } bus_st_e;
endpackage

// File: rtl/cwb_store_array.sv
module cwb_store_array #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int BW   = DW / 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_hit,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [BW-1:0] wr_be,
  input  logic          ret_en,
  input  logic [IW-1:0] ret_idx,
  input  logic [AW-1:0] lk_addr,
  output logic [DEPTH-1:0] hit_vec,
  output logic [DEPTH-1:0] valid_o,
  output logic [AW-1:0] addr_o [DEPTH],
  output logic [DW-1:0] data_o [DEPTH],
  output logic [BW-1:0] be_o   [DEPTH]
);
  logic [DEPTH-1:0] valid_q, valid_d;
  logic [AW-1:0] addr_q [DEPTH];
  logic [AW-1:0] addr_d [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [DW-1:0] data_d [DEPTH];
  logic [BW-1:0] be_q   [DEPTH];
  logic [BW-1:0] be_d   [DEPTH];
  logic          upd_en;

  assign upd_en = wr_en | ret_en;

  always_comb begin
    valid_d = valid_q;
    for (int i = 0; i < DEPTH; i++) begin
      addr_d[i] = addr_q[i];
      data_d[i] = data_q[i];
      be_d[i]   = be_q[i];
    end
    if (ret_en) valid_d[ret_idx] = 1'b0;
    if (wr_en) begin
      valid_d[wr_idx] = 1'b1;
      addr_d[wr_idx]  = wr_addr;
      if (wr_hit) begin
        be_d[wr_idx] = be_q[wr_idx] | wr_be;
        for (int b = 0; b < BW; b++)
          if (wr_be[b]) data_d[wr_idx][8*b +: 8] = wr_data[8*b +: 8];
      end else begin
        be_d[wr_idx] = wr_be;
        for (int b = 0; b < BW; b++)
          data_d[wr_idx][8*b +: 8] = wr_be[b] ? wr_data[8*b +: 8] : 8'h00;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      valid_q <= '0;
    else if (upd_en) valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i] <= addr_d[i];
        data_q[i] <= data_d[i];
        be_q[i]   <= be_d[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hit_vec[i] = valid_q[i] && (addr_q[i] == lk_addr);
      addr_o[i]  = addr_q[i];
      data_o[i]  = data_q[i];
      be_o[i]    = be_q[i];
    end
  end
  assign valid_o = valid_q;

  // R9
  retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(valid_q) < $countones($past(valid_q))) |-> $past(ret_en));
endmodule

// File: rtl/cwb_select.sv
module cwb_select #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] valid,
  input  logic [AW-1:0]    addr [DEPTH],
  output logic             free_any,
  output logic [IW-1:0]    free_idx,
  output logic [IW-1:0]    min_idx
);
  logic [AW-1:0] best;
  logic          seen;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_any = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

  always_comb begin
    seen    = 1'b0;
    best    = '0;
    min_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (valid[i] && (!seen || addr[i] < best)) begin
        seen    = 1'b1;
        best    = addr[i];
        min_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/coalesce_wbuf.sv
module coalesce_wbuf #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int BW   = DW / 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic          cpu_buf,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [BW-1:0] cpu_be,
  output logic          cpu_ack,
  output logic [DW-1:0] cpu_rdata,
  input  logic          drain_req,
  output logic          buf_empty,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [BW-1:0] mem_be,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  import cwb_pkg::*;

  localparam logic [DEPTH-1:0] ONE = {{(DEPTH-1){1'b0}}, 1'b1};

  bus_st_e st_q, st_d;
  logic [IW-1:0] infl_q, infl_d;
  logic          drain_q, drain_d;
  logic [AW-1:0] maddr_q, maddr_d;
  logic [DW-1:0] mdata_q, mdata_d;
  logic [BW-1:0] mbe_q, mbe_d;
  logic          mwe_q, mwe_d;
  logic          bus_load;

  logic [DEPTH-1:0] hit_vec, valid;
  logic [AW-1:0] e_addr [DEPTH];
  logic [DW-1:0] e_data [DEPTH];
  logic [BW-1:0] e_be   [DEPTH];
  logic          free_any;
  logic [IW-1:0] free_idx, min_idx;

  logic any_valid, full, is_bstore, is_block, stalled;
  logic launch_dir, launch_fl, accept, hit_any, ret_en;
  logic [DEPTH-1:0] infl_mask, launch_mask, hit_raw, hit_use;
  logic [IW-1:0] hit_idx, wr_idx;

  cwb_store_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(accept), .wr_hit(hit_any), .wr_idx(wr_idx),
    .wr_addr(cpu_addr), .wr_data(cpu_wdata), .wr_be(cpu_be),
    .ret_en(ret_en), .ret_idx(infl_q), .lk_addr(cpu_addr),
    .hit_vec(hit_vec), .valid_o(valid),
    .addr_o(e_addr), .data_o(e_data), .be_o(e_be)
  );

  cwb_select #(.DEPTH(DEPTH), .AW(AW)) i_sel (
    .valid(valid), .addr(e_addr),
    .free_any(free_any), .free_idx(free_idx), .min_idx(min_idx)
  );

  always_comb begin
    any_valid = |valid;
    full      = &valid;
    is_bstore = cpu_req && cpu_we && cpu_buf;
    is_block  = cpu_req && !(cpu_we && cpu_buf);
    infl_mask = (st_q == BUS_FLUSH) ? (ONE << infl_q) : '0;
    hit_raw   = hit_vec & ~infl_mask;
    stalled   = is_bstore && full && !(|hit_raw);
    launch_dir = (st_q == BUS_IDLE) && is_block && !any_valid;
    launch_fl  = (st_q == BUS_IDLE) && any_valid && (drain_q || is_block || stalled);
    launch_mask = launch_fl ? (ONE << min_idx) : '0;
    hit_use   = hit_raw & ~launch_mask;
    hit_any   = |hit_use;
    hit_idx   = '0;
    for (int i = 0; i < DEPTH; i++)
      if (hit_use[i]) hit_idx = IW'(i);
    wr_idx    = hit_any ? hit_idx : free_idx;
    accept    = is_bstore && (hit_any || free_any);
    ret_en    = (st_q == BUS_FLUSH) && mem_ack;
  end

  always_comb begin
    st_d     = st_q;
    infl_d   = infl_q;
    bus_load = 1'b0;
    maddr_d  = maddr_q;
    mdata_d  = mdata_q;
    mbe_d    = mbe_q;
    mwe_d    = mwe_q;
    unique case (st_q)
      BUS_IDLE: begin
        if (launch_dir) begin
          st_d = BUS_DIRECT;
          bus_load = 1'b1;
          maddr_d = cpu_addr;
          mdata_d = cpu_wdata;
          mbe_d   = cpu_be;
          mwe_d   = cpu_we;
        end else if (launch_fl) begin
          st_d = BUS_FLUSH;
          bus_load = 1'b1;
          infl_d  = min_idx;
          maddr_d = e_addr[min_idx];
          mdata_d = e_data[min_idx];
          mbe_d   = e_be[min_idx];
          mwe_d   = 1'b1;
        end
      end
      BUS_FLUSH, BUS_DIRECT: if (mem_ack) st_d = BUS_IDLE;
      default: st_d = BUS_IDLE;
    endcase
  end

  assign buf_empty = !any_valid && (st_q == BUS_IDLE);
  assign drain_d   = drain_req ? 1'b1 : (buf_empty ? 1'b0 : drain_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= BUS_IDLE;
      drain_q <= 1'b0;
      infl_q  <= '0;
    end else begin
      st_q    <= st_d;
      drain_q <= drain_d;
      if (launch_fl) infl_q <= infl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (bus_load) begin
      maddr_q <= maddr_d;
      mdata_q <= mdata_d;
      mbe_q   <= mbe_d;
      mwe_q   <= mwe_d;
    end
  end

  assign mem_req   = (st_q != BUS_IDLE);
  assign mem_addr  = maddr_q;
  assign mem_wdata = mdata_q;
  assign mem_be    = mbe_q;
  assign mem_we    = mwe_q;
  assign cpu_ack   = accept || ((st_q == BUS_DIRECT) && mem_ack);
  assign cpu_rdata = mem_rdata;

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)
                               && $stable(mem_be) && $stable(mem_we)));
  // R6
  direct_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_req && !(cpu_we && cpu_buf)) |-> mem_ack);
  // R7
  read_after_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req) && !mem_we) |-> $past(buf_empty));

  for (genvar i = 0; i < DEPTH; i++) begin : g_ui
    for (genvar j = i + 1; j < DEPTH; j++) begin : g_uj
      // R3
      uniq_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid[i] && valid[j] && !infl_mask[i] && !infl_mask[j]
          && (e_addr[i] == e_addr[j])));
    end
  end
endmodule

// File: tb/test_coalesce_wbuf.sv
module test_coalesce_wbuf;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n;
  logic cpu_req, cpu_we, cpu_buf, cpu_ack, drain_req, buf_empty;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic [3:0]  cpu_be;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  coalesce_wbuf i_coalesce_wbuf (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_buf(cpu_buf),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_ack(cpu_ack),
    .cpu_rdata(cpu_rdata), .drain_req(drain_req), .buf_empty(buf_empty),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] lg_addr [64];
  logic [31:0] lg_data [64];
  logic [3:0]  lg_be   [64];
  logic        lg_we   [64];
  int  nlog = 0;
  bit  hold = 0;
  int  dly = 1;
  int  cnt = 0;

  // memory model: answers an open request after dly cycles unless held
  always @(negedge clk) begin
    if (!rst_n || !mem_req || mem_ack) begin
      mem_ack = 1'b0;
      cnt = 0;
    end else if (cnt >= dly && !hold) begin
      mem_ack = 1'b1;
      mem_rdata = mem_addr ^ 32'h5A5A5A5A;
      if (nlog < 64) begin
        lg_addr[nlog] = mem_addr; lg_data[nlog] = mem_wdata;
        lg_be[nlog] = mem_be; lg_we[nlog] = mem_we;
      end
      nlog++;
    end else cnt++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_op(input bit we, input bit bf, input logic [31:0] a,
                        input logic [31:0] d, input logic [3:0] be,
                        output int waited, output logic [31:0] rd);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_buf = bf; cpu_addr = a; cpu_wdata = d; cpu_be = be;
    waited = 0;
    #1;
    while (!cpu_ack && waited < 3000) begin
      @(negedge clk); #1; waited++;
    end
    rd = cpu_rdata;
    @(posedge clk); #1;
    cpu_req = 0;
  endtask

  task automatic store(input bit bf, input logic [31:0] a, input logic [31:0] d,
                       input logic [3:0] be, input string req);
    int w; logic [31:0] rd;
    cpu_op(1'b1, bf, a, d, be, w, rd);
    if (bf) chk({req, " bufferable store ack same cycle"}, w, 0);
  endtask

  task automatic wait_empty(input string req);
    int n = 0;
    @(negedge clk); #1;
    while (!buf_empty && n < 3000) begin @(negedge clk); #1; n++; end
    chk({req, " buffer empties"}, buf_empty, 1);
  endtask

  task automatic drain();
    @(negedge clk); drain_req = 1;
    @(negedge clk); drain_req = 0;
    wait_empty("R8");
  endtask

  task automatic chk_log(input int i, input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] be, input bit we, input string req);
    chk({req, " bus addr"}, lg_addr[i], a);
    if (we) chk({req, " bus data"}, lg_data[i], d);
    chk({req, " bus be/we"}, {lg_be[i], 3'b0, lg_we[i]}, {be, 3'b0, we});
  endtask

  task automatic t_reset();
    rst_n = 0; cpu_req = 0; cpu_we = 0; cpu_buf = 0; cpu_addr = 0; cpu_wdata = 0;
    cpu_be = 0; drain_req = 0; mem_ack = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    chk("R1 empty in reset", buf_empty, 1);
    chk("R1 mem_req in reset", mem_req, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 empty after reset", buf_empty, 1);
    chk("R1 req/ack after reset", {mem_req, cpu_ack}, 0);
  endtask

  task automatic t_merge();
    int base = nlog;
    store(1, 32'h10, 32'h11223344, 4'hF, "R2");
    store(1, 32'h10, 32'h0000AA00, 4'h2, "R3");
    store(1, 32'h20, 32'h00000001, 4'h1, "R2");
    store(1, 32'h20, 32'h02000000, 4'h8, "R3");
    repeat (10) @(negedge clk);
    #1;
    chk("R2 no bus write before drain", nlog, base);
    chk("R8 not empty with parked entries", buf_empty, 0);
    drain();
    chk("R3 one write per merged word", nlog, base + 2);
    chk_log(base,     32'h10, 32'h1122AA44, 4'hF, 1, "R3");
    chk_log(base + 1, 32'h20, 32'h02000001, 4'h9, 1, "R3");
  endtask

  task automatic t_order();
    int base = nlog;
    store(1, 32'h33, 32'hCAFE0033, 4'hF, "R2");
    store(1, 32'h31, 32'hCAFE0031, 4'hF, "R2");
    store(1, 32'h32, 32'hCAFE0032, 4'hF, "R2");
    drain();
    chk("R4 count", nlog, base + 3);
    chk_log(base,     32'h31, 32'hCAFE0031, 4'hF, 1, "R4");
    chk_log(base + 1, 32'h32, 32'hCAFE0032, 4'hF, 1, "R4");
    chk_log(base + 2, 32'h33, 32'hCAFE0033, 4'hF, 1, "R4");
  endtask

  task automatic t_full();
    int base = nlog;
    int n = 0;
    hold = 1;
    store(1, 32'h43, 32'hCAFE0043, 4'hF, "R2");
    store(1, 32'h41, 32'hCAFE0041, 4'hF, "R2");
    store(1, 32'h42, 32'hCAFE0042, 4'hF, "R2");
    store(1, 32'h40, 32'hCAFE0040, 4'hF, "R2");
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_buf = 1; cpu_addr = 32'h50;
    cpu_wdata = 32'hCAFE0050; cpu_be = 4'hF;
    for (int k = 0; k < 5; k++) begin
      #1; chk("R5 stalled while full", cpu_ack, 0);
      @(negedge clk);
    end
    #1;
    chk("R4 lowest entry on bus first", mem_addr, 32'h40);
    chk("R9 request held", mem_req, 1);
    cpu_addr = 32'h41; cpu_wdata = 32'h0000EE00; cpu_be = 4'h2;
    #1; chk("R5 matching store taken while full", cpu_ack, 1);
    @(posedge clk); #1;
    @(negedge clk);
    cpu_addr = 32'h50; cpu_wdata = 32'hCAFE0050; cpu_be = 4'hF;
    #1; chk("R5 still stalled", cpu_ack, 0);
    hold = 0;
    while (!cpu_ack && n < 3000) begin @(negedge clk); #1; n++; end
    chk("R5 accepted after a drain completes", cpu_ack, 1);
    chk("R5 entry drained first", nlog, base + 1);
    @(posedge clk); #1; cpu_req = 0;
    drain();
    chk("R4 count", nlog, base + 5);
    chk_log(base,     32'h40, 32'hCAFE0040, 4'hF, 1, "R4");
    chk_log(base + 1, 32'h41, 32'hCAFEEE41, 4'hF, 1, "R3");
    chk_log(base + 2, 32'h42, 32'hCAFE0042, 4'hF, 1, "R4");
    chk_log(base + 3, 32'h43, 32'hCAFE0043, 4'hF, 1, "R4");
    chk_log(base + 4, 32'h50, 32'hCAFE0050, 4'hF, 1, "R4");
  endtask

  task automatic t_nonbuf();
    int base = nlog;
    dly = 3;
    store(1, 32'h61, 32'h00000061, 4'hF, "R2");
    store(1, 32'h60, 32'h00000060, 4'hF, "R2");
    store(0, 32'h60, 32'h00001111, 4'hF, "R6");
    chk("R6 ack only after its own transfer", nlog, base + 3);
    store(0, 32'h60, 32'h00002222, 4'h3, "R6");
    chk("R6 each write on bus", nlog, base + 4);
    chk_log(base,     32'h60, 32'h00000060, 4'hF, 1, "R6");
    chk_log(base + 1, 32'h61, 32'h00000061, 4'hF, 1, "R6");
    chk_log(base + 2, 32'h60, 32'h00001111, 4'hF, 1, "R6");
    chk_log(base + 3, 32'h60, 32'h00002222, 4'h3, 1, "R6");
    wait_empty("R8");
    dly = 1;
  endtask

  task automatic t_read();
    int base = nlog;
    int w; logic [31:0] rd;
    store(1, 32'h80, 32'h00000080, 4'hF, "R2");
    cpu_op(1'b0, 1'b1, 32'h05, 32'h0, 4'hF, w, rd);
    chk("R7 read data", rd, 32'h05 ^ 32'h5A5A5A5A);
    chk("R7 count", nlog, base + 2);
    chk_log(base,     32'h80, 32'h00000080, 4'hF, 1, "R7");
    chk_log(base + 1, 32'h05, 32'h0, 4'hF, 0, "R7");
    wait_empty("R8");
  endtask

  bit done = 0;
  initial begin
    t_reset();
    t_merge();
    t_order();
    t_full();
    t_nonbuf();
    t_read();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R9 watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule